// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that advances on one of several tick sources. A 3-bit clock-select field chooses the source. It can hold the count, count every system clock, or count on one of four taps of a shared, free-running 10-bit prescaler. It can also count on the falling or rising edge of an external count pin. The pin is brought into the system clock domain by a two-stage synchroniser. A two-state edge tracker then turns it into single-cycle edge pulses. Every tick source is a one-cycle enable in the system clock domain. No derived clocks are made.

Software loads the count and the select field through write strobes that share one data bus. When the count wraps from its maximum value back to zero, an overflow flag is set. The flag clears when software writes a one to it, or when the interrupt controller acknowledges the overflow. An interrupt controller would watch the flag. Firmware would reload the count to set the time to the next overflow.

The edge tracker has two states, EDGE_LOW and EDGE_HIGH. Its transitions are LOW_TO_HIGH, taken when the synchronised pin reads one in EDGE_LOW, and HIGH_TO_LOW, taken when it reads zero in EDGE_HIGH. LOW_TO_HIGH produces a rise pulse and HIGH_TO_LOW produces a fall pulse. Otherwise the tracker stays in its state.

Top module: `tmr8_prescaled_timer`

## Requirements
- R1: While rst_n is low, and after it is released, count_o reads 0, sel_o reads 000 and ovf_o reads 0.
- R2: With sel_o = 000 the count does not change, whatever the external pin does.
- R3: With sel_o = 001 the count rises by one on every clock edge.
- R4: Select codes 010, 011, 100 and 101 count once per 8, 64, 256 and 1024 clocks. The taps come from one 10-bit prescaler that starts at zero after reset and runs on every clock. Select writes do not restart it. The count advances on the edge where the low 3, 6, 8 or 10 prescaler bits are all ones, that is on edge j after reset when j mod N equals N-1.
- R5: Code 110 counts falling edges and code 111 counts rising edges of ext_pin. The pin is sampled on each rising clock edge. The count changes on the second clock edge after the edge that first samples the new level. Each level must be held for at least one clock.
- R6: A pulse on cnt_we loads wr_data into the count on the next edge. A tick in the same cycle is discarded, and counting resumes on the next tick after the write.
- R7: An increment that takes the count from 0xFF to 0x00 sets ovf_o on that edge.
- R8: flag_we with wr_data[0] = 1 clears ovf_o. With wr_data[0] = 0 it leaves ovf_o unchanged.
- R9: A pulse on ovf_ack clears ovf_o on the next edge.
- R10: If a wrap and a clear (write of one or acknowledge) fall in the same cycle, ovf_o is set afterwards.
- R11: A pulse on sel_we loads wr_data[2:0] into the select field on the next edge. The new source takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External count pin, asynchronous |
| wr_data | input | 8 | Shared write data |
| cnt_we | input | 1 | Load the count from wr_data |
| sel_we | input | 1 | Load the select field from wr_data[2:0] |
| flag_we | input | 1 | Flag write; wr_data[0] = 1 clears the flag |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| count_o | output | 8 | Current count |
| sel_o | output | 3 | Current clock-select field |
| ovf_o | output | 1 | Overflow flag |

## Verification
The counter runs under all eight select codes in turn. The four divided taps use the same stretch of cycles, so a wrong tap width or a prescaler that restarts on a select write shows up as a count that drifts from the expected sequence. The external modes are driven with pin pulses of one, two and three clocks. This separates falling from rising detection, shows the synchroniser latency, and exposes double counting of a single edge. Writes to the count and to the flag are placed on the same cycle as a tick or a wrap, which exposes the priority between load and increment and between set and clear.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } tmr_cs_e;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_st_e;

    localparam int unsigned NUM_TAPS = 4;

    // Number of low prescaler bits that must be all ones for each tap
    function automatic int unsigned tap_width(input int unsigned idx, input int unsigned pre_w);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return pre_w;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int unsigned PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tap_en
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned TW = tap_width(g, PRE_W);
        assign tap_en[g] = &pre_q[TW-1:0];
    end

    // R4: the finest tap never fires on two edges in a row
    p_tap_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[0] |=> !tap_en[0]);

    // R4: the coarsest tap only fires together with every finer tap
    p_tap_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[NUM_TAPS-1] |-> (&tap_en));

endmodule

// File: rtl/tmr8_ext_edge.sv
module tmr8_ext_edge
    import tmr8_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              pin_s;
    edge_st_e          st_q;
    edge_st_e          st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin_i};
        end
    end

    assign pin_s = sync_q[SYNC_N-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDGE_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and edge pulses
    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (st_q)
            EDGE_LOW: begin
                if (pin_s) begin
                    st_d   = EDGE_HIGH;
                    rise_o = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!pin_s) begin
                    st_d   = EDGE_LOW;
                    fall_o = 1'b1;
                end
            end
        endcase
    end

    // R5: one edge of the pin yields exactly one pulse
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr8_count_unit.sv
module tmr8_count_unit
    import tmr8_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_cs_e             sel_i,
    input  logic [NUM_TAPS-1:0] tap_en,
    input  logic                ext_rise,
    input  logic                ext_fall,
    input  logic                cnt_we,
    input  logic [CNT_W-1:0]    cnt_wdata,
    input  logic                flag_we,
    input  logic                flag_wbit,
    input  logic                ovf_ack,
    output logic [CNT_W-1:0]    count_o,
    output logic                ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             tick;
    logic             wrap;
    logic             clr;

    always_comb begin
        tick = 1'b0;
        unique case (sel_i)
            CS_STOP:     tick = 1'b0;
            CS_DIV1:     tick = 1'b1;
            CS_DIV8:     tick = tap_en[0];
            CS_DIV64:    tick = tap_en[1];
            CS_DIV256:   tick = tap_en[2];
            CS_DIV1024:  tick = tap_en[3];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
        endcase
    end

    assign wrap = tick && !cnt_we && (cnt_q == CNT_MAX);
    assign clr  = (flag_we && flag_wbit) || ovf_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = flag_q;

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == CS_STOP && !cnt_we) |=> $stable(count_o));

    p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_o == $past(cnt_wdata)));

    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && count_o == CNT_MAX) |=> (ovf_o && count_o == '0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !wrap) |=> !ovf_o);

    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && flag_we && flag_wbit) |=> ovf_o);

endmodule

// File: rtl/tmr8_prescaled_timer.sv
module tmr8_prescaled_timer
    import tmr8_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRE_W  = 10,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cnt_we,
    input  logic             sel_we,
    input  logic             flag_we,
    input  logic             ovf_ack,
    output logic [CNT_W-1:0] count_o,
    output logic [2:0]       sel_o,
    output logic             ovf_o
);

    tmr_cs_e             sel_q;
    logic [NUM_TAPS-1:0] tap_en;
    logic                ext_rise;
    logic                ext_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= CS_STOP;
        end else if (sel_we) begin
            sel_q <= tmr_cs_e'(wr_data[2:0]);
        end
    end

    assign sel_o = sel_q;

    tmr8_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_en (tap_en)
    );

    tmr8_ext_edge #(.SYNC_N(SYNC_N)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    tmr8_count_unit #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_q),
        .tap_en    (tap_en),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .cnt_we    (cnt_we),
        .cnt_wdata (wr_data),
        .flag_we   (flag_we),
        .flag_wbit (wr_data[0]),
        .ovf_ack   (ovf_ack),
        .count_o   (count_o),
        .ovf_o     (ovf_o)
    );

    p_sel_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_o == $past(wr_data[2:0])));

    p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(sel_o));

endmodule

// File: tb/test_tmr8_prescaled_timer.sv
`timescale 1ns/1ps
module test_tmr8_prescaled_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cnt_we = 1'b0;
    logic       sel_we = 1'b0;
    logic       flag_we = 1'b0;
    logic       ovf_ack = 1'b0;
    logic [7:0] count_o;
    logic [2:0] sel_o;
    logic       ovf_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    int m_cnt = 0;
    int m_sel = 0;
    int m_flag = 0;
    int m_cyc = 0;
    int pin_q[$] = '{0, 0, 0};

    always #10 clk = ~clk;

    tmr8_prescaled_timer i_tmr8_prescaled_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_pin (ext_pin),
        .wr_data (wr_data),
        .cnt_we  (cnt_we),
        .sel_we  (sel_we),
        .flag_we (flag_we),
        .ovf_ack (ovf_ack),
        .count_o (count_o),
        .sel_o   (sel_o),
        .ovf_o   (ovf_o)
    );

    task automatic model_step();
        int tick;
        int d;
        int wrap;
        int clr;
        if (!rst_n) begin
            m_cnt = 0; m_sel = 0; m_flag = 0; m_cyc = 0;
            pin_q = '{0, 0, 0};
            return;
        end
        tick = 0;
        d = 0;
        case (m_sel)
            1: tick = 1;
            2: d = 8;
            3: d = 64;
            4: d = 256;
            5: d = 1024;
            6: tick = (pin_q[$-2] == 1 && pin_q[$-1] == 0) ? 1 : 0;
            7: tick = (pin_q[$-2] == 0 && pin_q[$-1] == 1) ? 1 : 0;
            default: tick = 0;
        endcase
        if (d != 0) tick = ((m_cyc % d) == d - 1) ? 1 : 0;
        wrap = (tick == 1 && !cnt_we && m_cnt == 255) ? 1 : 0;
        clr  = ((flag_we && wr_data[0]) || ovf_ack) ? 1 : 0;
        if (wrap == 1) m_flag = 1;
        else if (clr == 1) m_flag = 0;
        if (cnt_we) m_cnt = int'(wr_data);
        else if (tick == 1) m_cnt = (m_cnt + 1) % 256;
        if (sel_we) m_sel = int'(wr_data[2:0]);
        pin_q.push_back(int'(ext_pin));
        if (pin_q.size() > 3) void'(pin_q.pop_front());
        m_cyc = m_cyc + 1;
    endtask

    task automatic compare();
        n_cmp++;
        if (int'(count_o) != m_cnt || int'(sel_o) != m_sel || int'(ovf_o) != m_flag) begin
            n_bad++;
            $display("FAIL %s t=%0t: count/sel/flag actual %0h/%0d/%0d expected %0h/%0d/%0d",
                     cur_req, $time, count_o, sel_o, ovf_o, m_cnt, m_sel, m_flag);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 model_step();
            @(negedge clk);
            compare();
            cnt_we = 1'b0; sel_we = 1'b0; flag_we = 1'b0; ovf_ack = 1'b0;
        end
    endtask

    task automatic set_sel(input int s);
        wr_data = 8'(s); sel_we = 1'b1;
        step(1);
    endtask

    task automatic load_cnt(input int v);
        wr_data = 8'(v); cnt_we = 1'b1;
        step(1);
    endtask

    task automatic pulse_pin(input int lvl, input int len);
        ext_pin = lvl[0];
        step(len);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state, while held and after release
        cur_req = "R1";
        ext_pin = 1'b1;
        step(3);
        ext_pin = 1'b0;
        rst_n = 1'b1;
        step(2);

        // R2: stopped, pin toggling has no effect
        cur_req = "R2";
        for (int i = 0; i < 10; i++) pulse_pin(i % 2, 2);

        // R11 / R3: every clock, run through a wrap (R7)
        cur_req = "R11";
        set_sel(1);
        cur_req = "R3";
        step(100);
        cur_req = "R7";
        step(200);

        // R8: write of zero keeps the flag, write of one clears it
        cur_req = "R8";
        set_sel(0);
        wr_data = 8'h00; flag_we = 1'b1; step(1);
        wr_data = 8'hFE; flag_we = 1'b1; step(1);
        wr_data = 8'h01; flag_we = 1'b1; step(1);
        step(2);

        // R4: divided taps, select writes do not restart the prescaler
        cur_req = "R4";
        set_sel(2); step(150);
        set_sel(3); step(300);
        set_sel(4); step(700);
        set_sel(5); step(2600);
        load_cnt(8'hFE); step(2200);

        // R6: load vs same-cycle tick, and resume afterwards
        cur_req = "R6";
        set_sel(1);
        load_cnt(8'h10); load_cnt(8'h80); step(3);
        load_cnt(8'hFF); load_cnt(8'hFF); step(2);

        // R9: acknowledge clears the flag
        cur_req = "R9";
        set_sel(0);
        ovf_ack = 1'b1; step(1);
        step(2);

        // R10: wrap and clear in the same cycle, flag stays set
        cur_req = "R10";
        set_sel(1);
        load_cnt(8'hFF);
        wr_data = 8'h01; flag_we = 1'b1; step(1);
        step(2);
        wr_data = 8'h01; flag_we = 1'b1; step(1);
        load_cnt(8'hFF);
        ovf_ack = 1'b1; step(1);
        step(2);

        // R5: external edges with pulses of 1, 2 and 3 clocks
        cur_req = "R5";
        set_sel(6);
        for (int len = 1; len <= 3; len++) begin
            for (int k = 0; k < 4; k++) begin
                pulse_pin(1, len);
                pulse_pin(0, len);
            end
        end
        step(4);
        set_sel(7);
        for (int len = 3; len >= 1; len--) begin
            for (int k = 0; k < 4; k++) begin
                pulse_pin(1, len);
                pulse_pin(0, len);
            end
        end
        step(4);
        load_cnt(8'hFF);
        pulse_pin(1, 2); pulse_pin(0, 4);

        // R2: pin activity after stopping leaves the count alone
        cur_req = "R2";
        set_sel(0);
        for (int i = 0; i < 8; i++) pulse_pin(i % 2, 1);
        step(4);

        finish_run();
    end

endmodule